// File: doc/BRIEF.md
# Store-Miss Line Fill Controller

This block takes a cacheable store that has already been looked up in a data cache. A miss to a line that is not already being fetched opens the single fill entry and requests the whole 32-byte line from external memory. The eight 32-bit words of the line come back one per valid beat, tagged with their index, in any order. When all eight are in, the controller takes the victim way chosen by the replacement logic. Each dirty 4-word half of a valid victim is sent to the write buffer as its own burst. Last, the returned line is written into the cache with the pending store words laid over it.

Stores to the line that is being fetched are merged into the open entry and are not stalled. Any other store that arrives while the entry is busy is stalled. The controller also handles stores it does not need to fetch for. A hit is written into the cache in the cycle it is accepted. A write-through store also goes out as a single-word write. A miss while the cache is disabled becomes a single-word write and allocates nothing.

Top module: `wa_fill_ctrl`

## Requirements
- R1: After reset the controller is idle: `stall`, `mem_rd_req`, `wb_valid` and `cw_en` are all low.
- R2: An accepted miss with `st_cache_en`=1 in the idle state raises `mem_rd_req` for exactly one cycle, the cycle after acceptance, with `mem_rd_addr` equal to the store address with bits 4:0 cleared.
- R3: While the fill is collecting words, a missing store to the same line is accepted without stall and without a second read request. Its word replaces the returned word at the same index in the final line write.
- R4: A store is stalled while the controller is busy unless R3 applies. A stalled store has no effect on any output, and `stall` is low whenever `st_valid` is low.
- R5: A fill word is taken on `mem_rd_valid` at index `mem_rd_idx`, in any order. The line counts as complete only when all eight indices have been received. No victim handling or line write starts before the cycle after the last word.
- R6: In the cycle after the last word, the victim inputs are sampled. If `vic_valid`=1, then for each set bit of `vic_dirty` (bit 0 = words 0-3, bit 1 = words 4-7) one burst goes out with `wb_burst`=1, one per cycle, lower half first. The lower half's address is the victim line address and the upper half's is that address plus 16. Word k of the half sits at `wb_data` bits 32k+31:32k. A clean or invalid victim produces no burst.
- R7: In the cycle after the last burst, or after the completion cycle if there is no burst, `cw_en`=1 and `cw_fill`=1 for one cycle. The write carries `cw_wmask`=all ones, `cw_way` = the sampled victim way and `cw_addr` = the line address. `cw_data` holds the returned words with the merged store words in their place.
- R8: On the line write, `cw_dirty` bit h is set if and only if the region is write-back and a store word fell in half h. For a write-through fill both bits are 0.
- R9: An accepted miss with `st_cache_en`=0 opens no fill. In the same cycle it issues `wb_valid`=1 and `wb_burst`=0, with `wb_addr`=`st_addr` and the store data in `wb_data` bits 31:0 and zeros above.
- R10: An accepted hit in the idle state writes the cache in the same cycle. The write carries `cw_fill`=0, `cw_way`=`st_way`, and a one-hot `cw_wmask` at the word index (address bits 4:2), with the data at that word's slot. In a write-back region it sets the `cw_dirty` bit of that word's half and issues no write-buffer request.
- R11: Every accepted write-through store, whether hit, miss or merge, issues a single-word write-buffer request in its accept cycle, formatted as in R9. A write-through hit sets no dirty bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| st_valid | input | 1 | Store request present |
| st_addr | input | ADDR_W | Word-aligned store byte address |
| st_data | input | WORD_W | Store data word |
| st_hit | input | 1 | Lookup result: line present |
| st_way | input | WAY_W | Way that hit |
| st_cache_en | input | 1 | Cache enabled |
| st_wt | input | 1 | Region is write-through |
| stall | output | 1 | Store not accepted this cycle |
| mem_rd_req | output | 1 | Line read request pulse |
| mem_rd_addr | output | ADDR_W | Line-aligned read address |
| mem_rd_valid | input | 1 | Fill word present |
| mem_rd_idx | input | IDX_W | Word index of the fill word |
| mem_rd_data | input | WORD_W | Fill word data |
| vic_way | input | WAY_W | Way to allocate |
| vic_valid | input | 1 | Victim line holds valid data |
| vic_dirty | input | 2 | Victim dirty bits per half |
| vic_line | input | ADDR_W-OFF_W | Victim line address |
| vic_data | input | LINE_W | Victim line contents |
| wb_valid | output | 1 | Write-buffer request |
| wb_burst | output | 1 | 1 = 4-word burst, 0 = single word |
| wb_addr | output | ADDR_W | Write address |
| wb_data | output | HALF_W | Write data, word 0 in low bits |
| cw_en | output | 1 | Cache write enable |
| cw_fill | output | 1 | 1 = line allocate, 0 = hit word write |
| cw_way | output | WAY_W | Way written |
| cw_addr | output | ADDR_W | Line address written |
| cw_wmask | output | LINE_WORDS | Word write mask |
| cw_data | output | LINE_W | Line data |
| cw_dirty | output | 2 | Dirty bits to set per half |

## Verification
Three results are due in the same cycle as their stimulus, because they are driven combinationally from the store inputs: stall, the single-word write-buffer request and the hit cache write. The read request follows one cycle after acceptance. The victim is sampled one cycle after the last fill word, each dirty burst takes its own cycle after that, and the line write comes one cycle after the last burst. The bench drives inputs just after a rising edge and compares every output at the falling edge. The comparison is against a behavioural model that advances its own fill state once per clock, using a queue of expected bursts. Each result is therefore checked in exactly the cycle it is due and never a cycle early or late.

// File: rtl/wa_fill_pkg.sv
// Shared types for the store-miss line fill controller.
package wa_fill_pkg;
    // Controller phase: idle, collecting words, writing back victim halves, writing line.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FILL  = 2'd1,
        ST_EVICT = 2'd2,
        ST_WRITE = 2'd3
    } fill_state_e;
endpackage

// File: rtl/line_gather.sv
// Collects the words of one line returned out of order.
// Assumes each index arrives once per fill; clear starts a new line.
module line_gather #(
    parameter int WORD_W     = 32,
    parameter int LINE_WORDS = 8,
    localparam int IDX_W     = $clog2(LINE_WORDS),
    localparam int LINE_W    = WORD_W * LINE_WORDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              in_valid,
    input  logic [IDX_W-1:0]  in_idx,
    input  logic [WORD_W-1:0] in_data,
    output logic [LINE_WORDS-1:0] rcvd,
    output logic [LINE_W-1:0] line_data,
    output logic              full
);
    logic [LINE_WORDS-1:0] rcvd_q;

    // Received mask: one bit per word index.
    always_ff @(posedge clk) begin
        if (!rst_n)        rcvd_q <= '0;
        else if (clear)    rcvd_q <= '0;
        else if (in_valid) rcvd_q[in_idx] <= 1'b1;
    end

    for (genvar w = 0; w < LINE_WORDS; w++) begin : g_word
        logic [WORD_W-1:0] word_q;
        // Capture the word whose index matches the incoming beat.
        always_ff @(posedge clk) begin
            if (!rst_n)                                  word_q <= '0;
            else if (in_valid && in_idx == IDX_W'(w))    word_q <= in_data;
        end
        assign line_data[w*WORD_W +: WORD_W] = word_q;
    end

    assign rcvd = rcvd_q;
    assign full = &rcvd_q;

    // R5
    dup_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !clear) |-> !rcvd_q[in_idx])
        else $error("fill word index received twice");
endmodule

// File: rtl/store_merge.sv
// Holds the store words waiting for the line fill, one slot per word index.
// load opens a new entry with the first store; merge adds a later store.
module store_merge #(
    parameter int WORD_W     = 32,
    parameter int LINE_WORDS = 8,
    localparam int IDX_W     = $clog2(LINE_WORDS),
    localparam int LINE_W    = WORD_W * LINE_WORDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              merge,
    input  logic [IDX_W-1:0]  idx,
    input  logic [WORD_W-1:0] data,
    output logic [LINE_WORDS-1:0] smask,
    output logic [LINE_W-1:0] sdata
);
    logic [LINE_WORDS-1:0] smask_q;
    logic [LINE_WORDS-1:0] onehot;

    assign onehot = LINE_WORDS'(1) << idx;

    // Word-present mask: reset on a new entry, accumulate on merges.
    always_ff @(posedge clk) begin
        if (!rst_n)     smask_q <= '0;
        else if (load)  smask_q <= onehot;
        else if (merge) smask_q <= smask_q | onehot;
    end

    for (genvar w = 0; w < LINE_WORDS; w++) begin : g_slot
        logic [WORD_W-1:0] slot_q;
        // Latest store data for this word index.
        always_ff @(posedge clk) begin
            if (!rst_n)                                     slot_q <= '0;
            else if ((load || merge) && idx == IDX_W'(w))   slot_q <= data;
        end
        assign sdata[w*WORD_W +: WORD_W] = slot_q;
    end

    assign smask = smask_q;

    // R3
    merge_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (merge && !load) |-> (smask_q != '0))
        else $error("merge without an open entry");
endmodule

// File: rtl/evict_seq.sv
// Sends the dirty halves of a victim line as 4-word bursts, lower half first,
// one burst per cycle. start samples the victim; assumes no burst is pending then.
module evict_seq #(
    parameter int ADDR_W     = 32,
    parameter int WORD_W     = 32,
    parameter int LINE_WORDS = 8,
    localparam int IDX_W     = $clog2(LINE_WORDS),
    localparam int OFF_W     = IDX_W + $clog2(WORD_W/8),
    localparam int LINE_W    = WORD_W * LINE_WORDS,
    localparam int HALF_W    = LINE_W / 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic                    vic_valid,
    input  logic [1:0]              vic_dirty,
    input  logic [ADDR_W-OFF_W-1:0] vic_line,
    input  logic [LINE_W-1:0]       vic_data,
    output logic                    burst_valid,
    output logic                    burst_last,
    output logic [ADDR_W-1:0]       burst_addr,
    output logic [HALF_W-1:0]       burst_data
);
    logic [1:0]              pend_q;
    logic [ADDR_W-OFF_W-1:0] line_q;
    logic [LINE_W-1:0]       data_q;
    logic                    sel_hi;

    // Pending halves: loaded from the victim, lower bit served first.
    always_ff @(posedge clk) begin
        if (!rst_n)          pend_q <= '0;
        else if (start)      pend_q <= vic_valid ? vic_dirty : 2'b00;
        else if (pend_q[0])  pend_q[0] <= 1'b0;
        else                 pend_q[1] <= 1'b0;
    end

    // Victim address and contents held for the bursts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= '0;
            data_q <= '0;
        end else if (start) begin
            line_q <= vic_line;
            data_q <= vic_data;
        end
    end

    assign sel_hi      = !pend_q[0];
    assign burst_valid = |pend_q;
    assign burst_last  = ^pend_q;
    assign burst_addr  = {line_q, sel_hi, {(OFF_W-1){1'b0}}};
    assign burst_data  = sel_hi ? data_q[LINE_W-1:HALF_W] : data_q[HALF_W-1:0];

    // R6
    upper_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_valid && burst_addr[OFF_W-1]) |=> !burst_valid)
        else $error("burst after the upper half");
    // R6
    start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !burst_valid)
        else $error("victim sampled while bursts pending");
endmodule

// File: rtl/wa_fill_ctrl.sv
// Store-miss line fill controller. A single fill entry: fetches the line,
// gathers words in any order, writes back dirty victim halves, then
// allocates the line with merged store data. Hits, write-through copies and
// disabled-cache misses pass straight through in the accept cycle.
// Assumes lookup (st_hit/st_way) and victim choice come from outside.
module wa_fill_ctrl
    import wa_fill_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int WORD_W     = 32,
    parameter int LINE_WORDS = 8,
    parameter int WAY_W      = 5,
    localparam int IDX_W      = $clog2(LINE_WORDS),
    localparam int BOFF_W     = $clog2(WORD_W/8),
    localparam int OFF_W      = IDX_W + BOFF_W,
    localparam int LINE_W     = WORD_W * LINE_WORDS,
    localparam int HALF_W     = LINE_W / 2,
    localparam int HALF_WORDS = LINE_WORDS / 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    st_valid,
    input  logic [ADDR_W-1:0]       st_addr,
    input  logic [WORD_W-1:0]       st_data,
    input  logic                    st_hit,
    input  logic [WAY_W-1:0]        st_way,
    input  logic                    st_cache_en,
    input  logic                    st_wt,
    output logic                    stall,
    output logic                    mem_rd_req,
    output logic [ADDR_W-1:0]       mem_rd_addr,
    input  logic                    mem_rd_valid,
    input  logic [IDX_W-1:0]        mem_rd_idx,
    input  logic [WORD_W-1:0]       mem_rd_data,
    input  logic [WAY_W-1:0]        vic_way,
    input  logic                    vic_valid,
    input  logic [1:0]              vic_dirty,
    input  logic [ADDR_W-OFF_W-1:0] vic_line,
    input  logic [LINE_W-1:0]       vic_data,
    output logic                    wb_valid,
    output logic                    wb_burst,
    output logic [ADDR_W-1:0]       wb_addr,
    output logic [HALF_W-1:0]       wb_data,
    output logic                    cw_en,
    output logic                    cw_fill,
    output logic [WAY_W-1:0]        cw_way,
    output logic [ADDR_W-1:0]       cw_addr,
    output logic [LINE_WORDS-1:0]   cw_wmask,
    output logic [LINE_W-1:0]       cw_data,
    output logic [1:0]              cw_dirty
);
    fill_state_e             state_q;
    logic [ADDR_W-OFF_W-1:0] line_q;
    logic                    wt_q;
    logic [WAY_W-1:0]        way_q;
    logic                    rdreq_q;

    logic [ADDR_W-OFF_W-1:0] st_line;
    logic [IDX_W-1:0]        st_word;
    logic                    busy, same_line, accept, start_fill, merge;
    logic                    single_wb, hit_wr, gather_done, go_evict;

    logic [LINE_WORDS-1:0]   rcvd, smask;
    logic [LINE_W-1:0]       line_data, sdata, merged;
    logic                    full;
    logic                    ev_valid, ev_last;
    logic [ADDR_W-1:0]       ev_addr;
    logic [HALF_W-1:0]       ev_data;

    assign st_line = st_addr[ADDR_W-1:OFF_W];
    assign st_word = st_addr[OFF_W-1:BOFF_W];

    // Acceptance: busy blocks all but same-line misses during the gather phase.
    assign busy        = (state_q != ST_IDLE);
    assign same_line   = (state_q == ST_FILL) && !st_hit && (st_line == line_q);
    assign stall       = st_valid && busy && !same_line;
    assign accept      = st_valid && !stall;
    assign start_fill  = accept && !busy && !st_hit && st_cache_en;
    assign merge       = accept && same_line;
    assign single_wb   = accept && (st_wt || (!st_hit && !st_cache_en));
    assign hit_wr      = accept && st_hit;
    assign gather_done = (state_q == ST_FILL) && full;
    assign go_evict    = vic_valid && (|vic_dirty);

    line_gather #(.WORD_W(WORD_W), .LINE_WORDS(LINE_WORDS)) u_gather (
        .clk(clk), .rst_n(rst_n), .clear(start_fill),
        .in_valid(mem_rd_valid && state_q == ST_FILL),
        .in_idx(mem_rd_idx), .in_data(mem_rd_data),
        .rcvd(rcvd), .line_data(line_data), .full(full)
    );

    store_merge #(.WORD_W(WORD_W), .LINE_WORDS(LINE_WORDS)) u_merge (
        .clk(clk), .rst_n(rst_n), .load(start_fill), .merge(merge),
        .idx(st_word), .data(st_data), .smask(smask), .sdata(sdata)
    );

    evict_seq #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .LINE_WORDS(LINE_WORDS)) u_evict (
        .clk(clk), .rst_n(rst_n), .start(gather_done),
        .vic_valid(vic_valid), .vic_dirty(vic_dirty),
        .vic_line(vic_line), .vic_data(vic_data),
        .burst_valid(ev_valid), .burst_last(ev_last),
        .burst_addr(ev_addr), .burst_data(ev_data)
    );

    // Phase sequencing of the single fill entry.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else begin
            unique case (state_q)
                ST_IDLE:  if (start_fill)  state_q <= ST_FILL;
                ST_FILL:  if (gather_done) state_q <= go_evict ? ST_EVICT : ST_WRITE;
                ST_EVICT: if (ev_last)     state_q <= ST_WRITE;
                ST_WRITE:                  state_q <= ST_IDLE;
                default:                   state_q <= ST_IDLE;
            endcase
        end
    end

    // Entry attributes and the one-cycle read request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q  <= '0;
            wt_q    <= 1'b0;
            way_q   <= '0;
            rdreq_q <= 1'b0;
        end else begin
            rdreq_q <= start_fill;
            if (start_fill) begin
                line_q <= st_line;
                wt_q   <= st_wt;
            end
            if (gather_done) way_q <= vic_way;
        end
    end

    assign mem_rd_req  = rdreq_q;
    assign mem_rd_addr = {line_q, {OFF_W{1'b0}}};

    for (genvar w = 0; w < LINE_WORDS; w++) begin : g_overlay
        assign merged[w*WORD_W +: WORD_W] = smask[w] ? sdata[w*WORD_W +: WORD_W]
                                                     : line_data[w*WORD_W +: WORD_W];
    end

    // Write-buffer port: victim bursts, else single-word pass-through.
    always_comb begin
        wb_valid = ev_valid || single_wb;
        wb_burst = ev_valid;
        wb_addr  = ev_valid ? ev_addr : st_addr;
        wb_data  = ev_valid ? ev_data : HALF_W'(st_data);
    end

    // Cache write port: line allocate in the write phase, else hit word write.
    always_comb begin
        cw_en    = 1'b0;
        cw_fill  = 1'b0;
        cw_way   = '0;
        cw_addr  = '0;
        cw_wmask = '0;
        cw_data  = '0;
        cw_dirty = 2'b00;
        if (state_q == ST_WRITE) begin
            cw_en    = 1'b1;
            cw_fill  = 1'b1;
            cw_way   = way_q;
            cw_addr  = {line_q, {OFF_W{1'b0}}};
            cw_wmask = '1;
            cw_data  = merged;
            cw_dirty = wt_q ? 2'b00 : {|smask[LINE_WORDS-1:HALF_WORDS], |smask[HALF_WORDS-1:0]};
        end else if (hit_wr) begin
            cw_en    = 1'b1;
            cw_way   = st_way;
            cw_addr  = {st_line, {OFF_W{1'b0}}};
            cw_wmask = LINE_WORDS'(1) << st_word;
            cw_data  = LINE_W'(st_data) << (st_word * WORD_W);
            cw_dirty = st_wt ? 2'b00 : (st_word[IDX_W-1] ? 2'b10 : 2'b01);
        end
    end

    // R2
    rdreq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |=> !mem_rd_req)
        else $error("read request longer than one cycle");
    // R5
    alloc_after_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cw_en && cw_fill) |-> (&rcvd))
        else $error("line allocated before all words arrived");
    // R6
    evict_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EVICT) |-> (wb_valid && wb_burst))
        else $error("eviction phase without a burst");
    // R4
    stall_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_valid |-> !stall)
        else $error("stall without a request");
    // R11
    wt_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cw_en && !cw_fill && st_wt) |-> (cw_dirty == 2'b00))
        else $error("write-through hit set a dirty bit");
endmodule

// File: tb/wa_fill_ctrl_bench.sv
module wa_fill_ctrl_bench;
    localparam int LW = 256;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         st_valid = 0, st_hit = 0, st_cache_en = 0, st_wt = 0;
    logic [31:0]  st_addr = '0, st_data = '0;
    logic [4:0]   st_way = '0;
    logic         stall, mem_rd_req;
    logic [31:0]  mem_rd_addr;
    logic         mem_rd_valid = 0;
    logic [2:0]   mem_rd_idx = '0;
    logic [31:0]  mem_rd_data = '0;
    logic [4:0]   vic_way = '0;
    logic         vic_valid = 0;
    logic [1:0]   vic_dirty = '0;
    logic [26:0]  vic_line = '0;
    logic [255:0] vic_data = '0;
    logic         wb_valid, wb_burst;
    logic [31:0]  wb_addr;
    logic [127:0] wb_data;
    logic         cw_en, cw_fill;
    logic [4:0]   cw_way;
    logic [31:0]  cw_addr;
    logic [7:0]   cw_wmask;
    logic [255:0] cw_data;
    logic [1:0]   cw_dirty;

    int checks = 0;
    int failures = 0;
    bit run_chk = 0;

    always #5 clk = ~clk;

    wa_fill_ctrl u_wa_fill_ctrl (
        .clk(clk), .rst_n(rst_n),
        .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data), .st_hit(st_hit),
        .st_way(st_way), .st_cache_en(st_cache_en), .st_wt(st_wt), .stall(stall),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid),
        .mem_rd_idx(mem_rd_idx), .mem_rd_data(mem_rd_data),
        .vic_way(vic_way), .vic_valid(vic_valid), .vic_dirty(vic_dirty),
        .vic_line(vic_line), .vic_data(vic_data),
        .wb_valid(wb_valid), .wb_burst(wb_burst), .wb_addr(wb_addr), .wb_data(wb_data),
        .cw_en(cw_en), .cw_fill(cw_fill), .cw_way(cw_way), .cw_addr(cw_addr),
        .cw_wmask(cw_wmask), .cw_data(cw_data), .cw_dirty(cw_dirty)
    );

    task automatic chk(input string tag, input logic [LW-1:0] act, input logic [LW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference: 0 idle, 1 gather, 2 write back, 3 line write.
    int           mst = 0;
    logic [26:0]  mline = '0;
    logic [7:0]   mrcvd = '0, msmask = '0;
    logic [31:0]  mword [8];
    logic [31:0]  mstw [8];
    logic         mwt = 0, rdp = 0;
    logic [4:0]   mway = '0;
    logic [31:0]  bq_addr [$];
    logic [127:0] bq_data [$];

    always @(negedge clk) begin
        if (!rst_n) begin
            // R1 outputs idle during and out of reset
            chk("R1 stall", LW'(stall), '0);
            chk("R1 mem_rd_req", LW'(mem_rd_req), '0);
            chk("R1 wb_valid", LW'(wb_valid), '0);
            chk("R1 cw_en", LW'(cw_en), '0);
        end else if (run_chk) begin
            logic [26:0] sl;
            int wi;
            bit same, estall, acc, ewv, eb, ecw, efull;
            logic [31:0] ea;
            logic [127:0] ed;
            logic [255:0] ecd;
            logic [7:0] emask;
            logic [1:0] edirty;
            sl = st_addr[31:5];
            wi = int'(st_addr[4:2]);
            same   = (mst == 1) && !st_hit && (sl == mline);
            estall = st_valid && (mst != 0) && !same;
            acc    = st_valid && !estall;
            chk(same ? "R3 stall" : "R4 stall", LW'(stall), LW'(estall));
            chk("R2 mem_rd_req", LW'(mem_rd_req), LW'(rdp));
            if (rdp) chk("R2 mem_rd_addr", LW'(mem_rd_addr), LW'({mline, 5'b0}));
            // expected write-buffer request
            ewv = 0; eb = 0; ea = '0; ed = '0;
            if (mst == 2) begin
                ewv = 1; eb = 1; ea = bq_addr[0]; ed = bq_data[0];
            end else if (acc && (st_wt || (!st_hit && !st_cache_en))) begin
                ewv = 1; ea = st_addr; ed = {96'b0, st_data};
            end
            chk(eb ? "R6 wb_valid" : (st_wt ? "R11 wb_valid" : "R9 wb_valid"), LW'(wb_valid), LW'(ewv));
            if (ewv) begin
                chk(eb ? "R6 wb_burst" : "R9 wb_burst", LW'(wb_burst), LW'(eb));
                chk(eb ? "R6 wb_addr" : "R9 wb_addr", LW'(wb_addr), LW'(ea));
                chk(eb ? "R6 wb_data" : "R11 wb_data", LW'(wb_data), LW'(ed));
            end
            // expected cache write
            ecw = (mst == 3) || (acc && st_hit);
            chk(mst != 0 ? "R5 cw_en" : "R10 cw_en", LW'(cw_en), LW'(ecw));
            if (mst == 3) begin
                for (int w = 0; w < 8; w++) ecd[w*32 +: 32] = msmask[w] ? mstw[w] : mword[w];
                edirty = mwt ? 2'b00 : {|msmask[7:4], |msmask[3:0]};
                chk("R7 cw_fill", LW'(cw_fill), LW'(1));
                chk("R7 cw_way", LW'(cw_way), LW'(mway));
                chk("R7 cw_addr", LW'(cw_addr), LW'({mline, 5'b0}));
                chk("R7 cw_wmask", LW'(cw_wmask), LW'(8'hFF));
                chk("R3 R7 cw_data", cw_data, ecd);
                chk("R8 cw_dirty", LW'(cw_dirty), LW'(edirty));
            end else if (ecw) begin
                emask = '0; emask[wi] = 1'b1;
                ecd = '0; ecd[wi*32 +: 32] = st_data;
                edirty = st_wt ? 2'b00 : (wi >= 4 ? 2'b10 : 2'b01);
                chk("R10 cw_fill", LW'(cw_fill), LW'(0));
                chk("R10 cw_way", LW'(cw_way), LW'(st_way));
                chk("R10 cw_addr", LW'(cw_addr), LW'({sl, 5'b0}));
                chk("R10 cw_wmask", LW'(cw_wmask), LW'(emask));
                chk("R10 cw_data", cw_data, ecd);
                chk(st_wt ? "R11 cw_dirty" : "R10 cw_dirty", LW'(cw_dirty), LW'(edirty));
            end
            // advance model to the next rising edge
            rdp = 0;
            case (mst)
                0: if (acc && !st_hit && st_cache_en) begin
                    mst = 1; mline = sl; mrcvd = '0; mwt = st_wt; rdp = 1;
                    msmask = '0; msmask[wi] = 1'b1; mstw[wi] = st_data;
                end
                1: begin
                    efull = (mrcvd == 8'hFF);
                    if (mem_rd_valid) begin
                        mrcvd[mem_rd_idx] = 1'b1; mword[mem_rd_idx] = mem_rd_data;
                    end
                    if (acc && same) begin
                        msmask[wi] = 1'b1; mstw[wi] = st_data;
                    end
                    if (efull) begin
                        mway = vic_way;
                        if (vic_valid && vic_dirty[0]) begin
                            bq_addr.push_back({vic_line, 5'b0}); bq_data.push_back(vic_data[127:0]);
                        end
                        if (vic_valid && vic_dirty[1]) begin
                            bq_addr.push_back({vic_line, 5'b10000}); bq_data.push_back(vic_data[255:128]);
                        end
                        mst = (bq_addr.size() > 0) ? 2 : 3;
                    end
                end
                2: begin
                    void'(bq_addr.pop_front()); void'(bq_data.pop_front());
                    if (bq_addr.size() == 0) mst = 3;
                end
                default: mst = 0;
            endcase
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic put_store(input logic [31:0] a, input logic [31:0] d, input bit hit,
                             input bit en, input bit wt);
        st_valid = 1; st_addr = a; st_data = d; st_hit = hit; st_way = 5'd17;
        st_cache_en = en; st_wt = wt;
    endtask

    task automatic put_word(input int i, input int scen);
        mem_rd_valid = 1; mem_rd_idx = 3'(i); mem_rd_data = 32'hD000_0000 | (scen << 8) | i;
    endtask

    task automatic idle_inputs();
        st_valid = 0; mem_rd_valid = 0;
    endtask

    task automatic set_victim(input bit v, input logic [1:0] d, input logic [26:0] ln,
                              input logic [4:0] way);
        vic_valid = v; vic_dirty = d; vic_line = ln; vic_way = way;
        for (int w = 0; w < 8; w++) vic_data[w*32 +: 32] = {ln[15:0], 16'(w + 16'hA0)};
    endtask

    initial begin
        #200000;
        failures++;
        $display("FAIL R1 watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1; run_chk = 1;
        tick();
        // A: write-back miss, shuffled words, merge, stalled store, both halves dirty
        set_victim(1, 2'b11, 27'h40921, 5'd9);
        put_store(32'h0000_4A48, 32'hAAAA_0002, 0, 1, 0); tick(); idle_inputs();
        tick();
        put_word(5, 1); tick(); put_word(1, 1); tick(); idle_inputs(); tick();
        put_word(7, 1); tick();
        put_word(0, 1); put_store(32'h0000_4A58, 32'hBBBB_0006, 0, 1, 0); tick(); idle_inputs();
        put_store(32'h0000_9000, 32'hCCCC_0000, 0, 1, 0); tick(); idle_inputs();
        put_word(3, 1); tick(); put_word(6, 1); tick(); put_word(2, 1); tick();
        put_word(4, 1); tick(); idle_inputs();
        repeat (6) tick();
        // B: write-through miss, reverse order, upper half dirty, hit stalled
        set_victim(1, 2'b10, 27'h1234, 5'd3);
        put_store(32'h0000_7704, 32'h1111_0001, 0, 1, 1); tick(); idle_inputs();
        for (int i = 7; i >= 0; i--) begin
            put_word(i, 2);
            if (i == 4) put_store(32'h0000_0100, 32'h2222_0000, 1, 1, 0);
            if (i == 3) put_store(32'h0000_771C, 32'h3333_0007, 0, 1, 1);
            tick(); idle_inputs();
        end
        repeat (6) tick();
        // C: invalid victim with dirty bits set, in-order words
        set_victim(0, 2'b11, 27'h5555, 5'd30);
        put_store(32'h0001_0030, 32'h4444_0004, 0, 1, 0); tick(); idle_inputs();
        for (int i = 0; i < 8; i++) begin put_word(i, 3); tick(); end
        idle_inputs();
        repeat (5) tick();
        // D: clean valid victim, disabled miss stalled while busy
        set_victim(1, 2'b00, 27'h6666, 5'd12);
        put_store(32'h0002_0000, 32'h5555_0000, 0, 1, 0); tick(); idle_inputs();
        for (int i = 0; i < 8; i++) begin
            put_word((i * 3) % 8, 4);
            if (i == 2) put_store(32'h0003_0004, 32'h6666_0001, 0, 0, 0);
            tick(); idle_inputs(); tick();
        end
        repeat (5) tick();
        // E: idle pass-through stores
        put_store(32'h0000_0254, 32'h7777_0005, 1, 1, 0); tick();
        put_store(32'h0000_0308, 32'h8888_0002, 1, 1, 1); tick();
        put_store(32'h0000_040C, 32'h9999_0003, 0, 0, 0); tick();
        put_store(32'h0000_0510, 32'hAAAA_0004, 0, 0, 1); tick();
        idle_inputs();
        repeat (3) tick();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule